// File: doc/BRIEF.md
# Vector Unzip Permute Unit

This block splits two interleaved vectors back into their separate streams. The two source vectors are joined into one double-width value, with the second source above the first. The result takes every other element of that value. A select input chooses the even positions or the odd positions. Used once with each select value on the same pair of sources, the block yields both de-interleaved halves.

The element size (8, 16, 32 or 64 bits) and the working width (64 or 128 bits) are set by inputs on every cycle, so each transfer can use a different arrangement. One arrangement is reserved: 64-bit elements at 64-bit width. It raises an undefined flag and yields an all-zero vector. The permute itself is pure wiring and multiplexing. A parameter adds an output register with a valid bit. In that case the latency is one cycle for every operand value and every arrangement.

Top module: `vunzip_unit`

## Requirements
- R1: The 2-bit size code selects the element width as 8 << code: code 0 gives 8-bit, 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit elements.
- R2: With `wide`=1 the unit works on all 128 bits of each source. With `wide`=0 it works only on bits 63:0 of each source. The element count is the working width divided by the element width.
- R3: Result element e equals element 2*e+`odd_sel` of the double-width value {second source, first source}, for all e below the element count. With `odd_sel`=0 the even elements are chosen.
- R4: With `odd_sel`=1, the odd elements of the first source (`src_lo`) fill the lower half of the working width, in order, and the odd elements of the second source (`src_hi`) fill the upper half.
- R5: With `wide`=0, bits 127:64 of the result are zero.
- R6: Size code 3 with `wide`=0 is reserved. It sets `out_undef`=1 and forces the whole result to zero. Every other combination gives `out_undef`=0.
- R7: With the output register present (`REG_OUT`=1), `out_valid` equals `in_valid` from the previous cycle. The result for that input appears in the same cycle, whatever the operand values and whether or not the arrangement is reserved.
- R8: A synchronous active-high `rst` clears `out_valid` at the next clock edge.
- R9: In a cycle with `in_valid`=0, the registered `out_vec` and `out_undef` keep their values, even if the other inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_lo | input | 128 | First source vector, forms the lower half of the joined value |
| src_hi | input | 128 | Second source vector, forms the upper half of the joined value |
| elem_size | input | 2 | Element size code (R1) |
| wide | input | 1 | 1: 128-bit working width, 0: 64-bit |
| odd_sel | input | 1 | 1: take odd positions, 0: take even positions |
| out_valid | output | 1 | Result valid |
| out_vec | output | 128 | Unzipped result vector |
| out_undef | output | 1 | Reserved arrangement was requested |

## Verification
The hardest cases to reach are the element positions where the source switches from the first operand to the second. At those positions a wrong lane offset changes only a few result bits. To expose them, the bench runs every legal size, width and select combination with random operands. It also uses fixed byte-ramp operands, in which every byte is different, so an element taken from the wrong place can never produce the expected value by chance. The reserved arrangement is sent with nonzero data and between legal items, and the zeroed result and flag are checked. Idle cycles carry changed operands to show that the registered output holds.

// File: rtl/vunzip_pkg.sv
package vunzip_pkg;
    localparam int VEC_W     = 128;
    localparam int HALF_W    = VEC_W / 2;
    localparam int MIN_ESIZE = 8;
    localparam int NSIZES    = 4;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_DBL  = 2'd3
    } esize_e;

    typedef struct packed {
        logic             valid;
        logic             undef;
        logic [VEC_W-1:0] data;
    } vout_t;
endpackage

// File: rtl/vunzip_decode.sv
module vunzip_decode
    import vunzip_pkg::*;
(
    input  logic [1:0]        elem_size,
    input  logic              wide,
    output logic [NSIZES-1:0] lane_sel,
    output logic              undef
);
    always_comb begin
        undef    = (esize_e'(elem_size) == ESZ_DBL) && !wide;
        lane_sel = '0;
        if (!undef) begin
            lane_sel[elem_size] = 1'b1;
        end
    end
endmodule

// File: rtl/vunzip_gather.sv
module vunzip_gather #(
    parameter int VEC_W = 128,
    parameter int ESIZE = 8
) (
    input  logic [VEC_W-1:0] src_lo,
    input  logic [VEC_W-1:0] src_hi,
    input  logic             wide,
    input  logic             odd_sel,
    output logic [VEC_W-1:0] res
);
    localparam int HALF_W = VEC_W / 2;
    localparam int NFULL  = VEC_W / ESIZE;
    localparam int NHALF  = HALF_W / ESIZE;

    logic [2*VEC_W-1:0] zip_full;
    logic [VEC_W-1:0]   zip_half;
    logic [VEC_W-1:0]   res_full;
    logic [HALF_W-1:0]  res_half;

    assign zip_full = {src_hi, src_lo};
    assign zip_half = {src_hi[HALF_W-1:0], src_lo[HALF_W-1:0]};

    for (genvar e = 0; e < NFULL; e++) begin : g_full
        assign res_full[e*ESIZE +: ESIZE] = odd_sel ? zip_full[(2*e+1)*ESIZE +: ESIZE]
                                                    : zip_full[(2*e)*ESIZE +: ESIZE];
    end

    for (genvar e = 0; e < NHALF; e++) begin : g_half
        assign res_half[e*ESIZE +: ESIZE] = odd_sel ? zip_half[(2*e+1)*ESIZE +: ESIZE]
                                                    : zip_half[(2*e)*ESIZE +: ESIZE];
    end

    assign res = wide ? res_full : {{HALF_W{1'b0}}, res_half};
endmodule

// File: rtl/vunzip_unit.sv
module vunzip_unit
    import vunzip_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_lo,
    input  logic [VEC_W-1:0] src_hi,
    input  logic [1:0]       elem_size,
    input  logic             wide,
    input  logic             odd_sel,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_undef
);
    logic [NSIZES-1:0] lane_sel;
    logic              undef_c;
    logic [VEC_W-1:0]  cand [NSIZES];
    logic [VEC_W-1:0]  perm_c;
    vout_t             out_d;
    vout_t             out_q;

    vunzip_decode u_dec (
        .elem_size (elem_size),
        .wide      (wide),
        .lane_sel  (lane_sel),
        .undef     (undef_c)
    );

    for (genvar i = 0; i < NSIZES; i++) begin : g_size
        vunzip_gather #(
            .VEC_W (VEC_W),
            .ESIZE (MIN_ESIZE << i)
        ) u_gather (
            .src_lo  (src_lo),
            .src_hi  (src_hi),
            .wide    (wide),
            .odd_sel (odd_sel),
            .res     (cand[i])
        );
    end

    // AND-OR select: an empty lane_sel (reserved case) yields zero
    always_comb begin
        perm_c = '0;
        for (int i = 0; i < NSIZES; i++) begin
            perm_c = perm_c | (cand[i] & {VEC_W{lane_sel[i]}});
        end
    end

    if (REG_OUT) begin : g_reg
        always_comb begin
            out_d       = out_q;
            out_d.valid = in_valid;
            if (in_valid) begin
                out_d.undef = undef_c;
                out_d.data  = perm_c;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end
    end else begin : g_comb
        always_comb begin
            out_d.valid = in_valid;
            out_d.undef = undef_c;
            out_d.data  = perm_c;
        end
        assign out_q = out_d;
    end

    assign out_valid = out_q.valid;
    assign out_vec   = out_q.data;
    assign out_undef = out_q.undef;
endmodule

// File: rtl/vunzip_checker.sv
module vunzip_checker #(
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [127:0] src_lo,
    input logic [127:0] src_hi,
    input logic [1:0]   elem_size,
    input logic         wide,
    input logic         odd_sel,
    input logic         out_valid,
    input logic [127:0] out_vec,
    input logic         out_undef
);
    if (REG_OUT) begin : g_chk
        assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        assert_idle_follow_R7: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        assert_reset_clear_R8: assert property (@(posedge clk)
            rst |=> !out_valid);
        assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && elem_size == 2'd3 && !wide) |=> (out_undef && out_vec == '0));
        assert_legal_flag_R6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (wide || elem_size != 2'd3)) |=> !out_undef);
        assert_half_upper_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !wide) |=> (out_vec[127:64] == '0));
        assert_byte_odd_R4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && elem_size == 2'd0 && wide && odd_sel) |=>
            (out_vec[7:0] == $past(src_lo[15:8]) && out_vec[127:120] == $past(src_hi[127:120])));
        assert_dbl_even_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && elem_size == 2'd3 && wide && !odd_sel) |=>
            (out_vec == {$past(src_hi[63:0]), $past(src_lo[63:0])}));
        assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (!in_valid && !$past(rst)) |=> ($stable(out_vec) && $stable(out_undef)));
    end
endmodule

bind vunzip_unit vunzip_checker #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_lo    (src_lo),
    .src_hi    (src_hi),
    .elem_size (elem_size),
    .wide      (wide),
    .odd_sel   (odd_sel),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .out_undef (out_undef)
);

// File: tb/vunzip_unit_test.sv
`timescale 1ns/1ps
module vunzip_unit_test;
    typedef struct {
        logic [127:0] vec;
        logic         undef;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_lo = '0;
    logic [127:0] src_hi = '0;
    logic [1:0]   elem_size = '0;
    logic         wide = 1'b0;
    logic         odd_sel = 1'b0;
    logic         out_valid;
    logic [127:0] out_vec;
    logic         out_undef;

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #4 clk = ~clk;

    vunzip_unit uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_lo    (src_lo),
        .src_hi    (src_hi),
        .elem_size (elem_size),
        .wide      (wide),
        .odd_sel   (odd_sel),
        .out_valid (out_valid),
        .out_vec   (out_vec),
        .out_undef (out_undef)
    );

    // Loop model written from R1, R2, R3, R5, R6
    function automatic exp_t model(input logic [127:0] a, input logic [127:0] b,
                                   input logic [1:0] sz, input logic w, input logic part);
        exp_t         r;
        int           es;
        int           dw;
        int           ne;
        logic [255:0] joined;
        es = 8 << sz;
        dw = w ? 128 : 64;
        ne = dw / es;
        r.vec = '0;
        r.undef = (sz == 2'd3) && !w;
        if (w) joined = {b, a};
        else   joined = {128'b0, b[63:0], a[63:0]};
        if (!r.undef) begin
            for (int e = 0; e < ne; e++) begin
                for (int k = 0; k < es; k++) begin
                    r.vec[e*es + k] = joined[(2*e + part)*es + k];
                end
            end
        end
        if (r.undef)    r.tag = "R6";
        else if (!w)    r.tag = "R5/R2";
        else if (part)  r.tag = "R4/R1";
        else            r.tag = "R3/R1";
        return r;
    endfunction

    task automatic send(input logic [127:0] a, input logic [127:0] b,
                        input logic [1:0] sz, input logic w, input logic part);
        @(negedge clk);
        src_lo = a; src_hi = b; elem_size = sz; wide = w; odd_sel = part;
        in_valid = 1'b1;
        last_exp = model(a, b, sz, w, part);
        sb_q.push_back(last_exp);
    endtask

    task automatic idle_cycle;
        @(negedge clk);
        in_valid = 1'b0;
        src_lo = {$urandom, $urandom, $urandom, $urandom};
        src_hi = {$urandom, $urandom, $urandom, $urandom};
        odd_sel = ~odd_sel;
        elem_size = elem_size + 2'd1;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Monitor: pops the scoreboard whenever a result is presented (R7)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && out_valid) begin
                n_cmp++;
                if (sb_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R7: unexpected out_valid, actual=1 expected=0");
                end else begin
                    exp_t x;
                    x = sb_q.pop_front();
                    if (out_vec !== x.vec || out_undef !== x.undef) begin
                        n_bad++;
                        $display("FAIL %s: actual vec=%h undef=%b expected vec=%h undef=%b",
                                 x.tag, out_vec, out_undef, x.vec, x.undef);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] ramp_a;
        logic [127:0] ramp_b;
        for (int i = 0; i < 16; i++) begin
            ramp_a[i*8 +: 8] = 8'(i);
            ramp_b[i*8 +: 8] = 8'(8'h80 + i);
        end

        // Reset state (R8)
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R8: reset out_valid actual=%b expected=0", out_valid);
        end
        @(negedge clk);
        rst = 1'b0;

        // Deterministic ramps, every legal arrangement and both selects (R1-style sweep: R1, R2, R3, R4)
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 4; s++) begin
                for (int p = 0; p < 2; p++) begin
                    if (!(s == 3 && w == 0)) send(ramp_a, ramp_b, 2'(s), 1'(w), 1'(p));
                end
            end
        end

        // Random operands over all combinations, reserved included (R6 interleaved)
        for (int r = 0; r < 10; r++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int p = 0; p < 2; p++) begin
                        send(rnd128(), rnd128(), 2'(s), 1'(w), 1'(p));
                    end
                end
            end
        end

        // Reserved case with all-ones data, then a legal item right after (R6)
        send({128{1'b1}}, {128{1'b1}}, 2'd3, 1'b0, 1'b1);
        send({128{1'b1}}, {128{1'b1}}, 2'd0, 1'b0, 1'b1);

        // Hold while idle with changed inputs (R9)
        send(rnd128(), rnd128(), 2'd1, 1'b1, 1'b1);
        idle_cycle();
        @(posedge clk);
        #2;
        n_cmp++;
        if (out_valid !== 1'b0 || out_vec !== last_exp.vec || out_undef !== last_exp.undef) begin
            n_bad++;
            $display("FAIL R9: actual valid=%b vec=%h expected valid=0 vec=%h",
                     out_valid, out_vec, last_exp.vec);
        end
        idle_cycle();
        @(posedge clk);
        #2;
        n_cmp++;
        if (out_vec !== last_exp.vec) begin
            n_bad++;
            $display("FAIL R9: second idle actual=%h expected=%h", out_vec, last_exp.vec);
        end

        // Back-to-back then reset with in_valid high (R7, R8)
        send(rnd128(), rnd128(), 2'd2, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        #2;
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R8: after reset out_valid actual=%b expected=0", out_valid);
        end
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #2;

        // Every pushed item must have come out (R7)
        n_cmp++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7: pending items actual=%0d expected=0", sb_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule